// File: doc/BRIEF.md
# System Configuration Controller

This block is a bank of 32-bit registers on a simple memory-mapped bus. Software uses it to hold general configuration words and to drive a remap line and a row of LEDs. It also reads a set of switch inputs, reads fixed identification words, and adjusts the top byte of a loop status word. A write lands on the rising clock edge where `bus_sel` and `bus_write` are both high. Read data is a combinational function of `bus_addr`, so it is valid in the same cycle as the address.

A small mailbox inside the block sets the oscillator frequency words. Software does three things:

- It places a value in the data-out register.
- It writes the control register with the start bit, a direction bit, a function code and a device index.
- It reads the status register.

The transaction completes on the same clock edge as the control write. A valid write copies data-out into the selected oscillator word. A valid read copies that word into the return-data register. A function code other than 1, or a device index at or above the number of oscillators, sets the error flag and touches nothing.

Top module: `syscfg_ctrl`

## Requirements
- R1: After reset the registers hold these values:
  - configuration word 0 holds parameter `CFG0_RST`;
  - control reads 0x00100000;
  - the loop status word reads 0xFFFF0001;
  - oscillator word i holds bits [32i+31:32i] of parameter `OSC_RST`;
  - configuration words 1, 2, 5, 6 and 7, data-out, return-data and status read zero.
- R2: The register byte offsets are:
  - 0x000, 0x004, 0x008, 0x00C, 0x010, 0x014, 0x018 and 0x01C for configuration words 0 to 7;
  - 0x0A0 data-out, 0x0A4 return-data, 0x0A8 control and 0x0AC status;
  - 0x100 loop status, 0xFF8 auxiliary identity and 0xFFC identity.

  Writable configuration words (0, 1, 2, 5, 6, 7) and data-out read back what was last written. Any other offset reads zero.
- R3: Bit 0 of configuration word 0 drives `remap_o` from the clock edge that writes it.
- R4: Bits [NUM_LEDS-1:0] of configuration word 1 drive `led_o` (bit i to LED i, active high). Higher bits are stored but drive no output.
- R5: Configuration word 3 reads `switch_in` zero-extended. Configuration word 4, auxiliary identity and identity read parameters `CFG4_VAL`, `AID_VAL` and `ID_VAL`. Bus writes to these four have no effect.
- R6: The control register keeps only these bits of a bus write and stores zero in all others:
  - bit 30 (write direction);
  - bits 25:20 (function code);
  - bits 11:0 (device index).

  Bit 31 (start) therefore always reads back 0.
- R7: Any control write clears status. If bit 31 of the written value is 1, status bit 0 (done) reads 1 from the next cycle. Status keeps its value until the next control write.
- R8: A start with bit 30 = 1, function 1 and device d < NUM_OSC copies data-out into oscillator word d.
- R9: A start with bit 30 = 0, function 1 and device d < NUM_OSC copies oscillator word d into return-data.
- R10: A start with function ≠ 1 or device ≥ NUM_OSC sets status to 0x3 (done and bit 1, error). It leaves every oscillator word and return-data unchanged.
- R11: A bus write to the loop status word replaces bits 31:24 and leaves bits 23:0 unchanged.
- R12: Bus writes to return-data and status have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| switch_in | input | SW_W | Switch levels read through configuration word 3 |
| remap_o | output | 1 | Remap control line |
| led_o | output | NUM_LEDS | LED drive, active high |

## Verification
The bench builds the block with the following settings:

- three oscillators, each with a distinct reset word, so a read of any device shows which word was returned;
- eight LEDs, with a ninth written bit that must not reach a pin;
- an 8-bit switch bus;
- a configuration-0 reset value of 1, so the remap line starts high and its fall on a write is visible.

With three oscillators, device 2 is the last legal index and device 3 the first illegal one, which tests the range check at both sides. The non-zero identity parameters show that writes to read-only locations leave their values in place.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned NUM_REGS = 15;

   localparam logic [11:0] OFS_CFG0 = 12'h000;
   localparam logic [11:0] OFS_CFG1 = 12'h004;
   localparam logic [11:0] OFS_CFG2 = 12'h008;
   localparam logic [11:0] OFS_CFG3 = 12'h00C;
   localparam logic [11:0] OFS_CFG4 = 12'h010;
   localparam logic [11:0] OFS_CFG5 = 12'h014;
   localparam logic [11:0] OFS_CFG6 = 12'h018;
   localparam logic [11:0] OFS_CFG7 = 12'h01C;
   localparam logic [11:0] OFS_DOUT = 12'h0A0;
   localparam logic [11:0] OFS_RTN  = 12'h0A4;
   localparam logic [11:0] OFS_CTRL = 12'h0A8;
   localparam logic [11:0] OFS_STAT = 12'h0AC;
   localparam logic [11:0] OFS_DLL  = 12'h100;
   localparam logic [11:0] OFS_AID  = 12'hFF8;
   localparam logic [11:0] OFS_ID   = 12'hFFC;

   // control field positions
   localparam int unsigned CTL_START  = 31;
   localparam int unsigned CTL_WRITE  = 30;
   localparam int unsigned CTL_FN_LSB = 20;
   localparam int unsigned CTL_FN_W   = 6;
   localparam int unsigned CTL_DEV_W  = 12;

   localparam logic [WORD_W-1:0] CTL_KEEP   = 32'h43F0_0FFF;
   localparam logic [WORD_W-1:0] CTL_RST    = 32'h0010_0000;
   localparam logic [WORD_W-1:0] DLL_RST    = 32'hFFFF_0001;
   localparam logic [WORD_W-1:0] DLL_WRMASK = 32'hFF00_0000;
   localparam logic [CTL_FN_W-1:0] FN_OSC   = 6'd1;

   typedef enum logic [3:0] {
      RG_CFG0, RG_CFG1, RG_CFG2, RG_CFG3, RG_CFG4, RG_CFG5, RG_CFG6, RG_CFG7,
      RG_DOUT, RG_RTN, RG_CTRL, RG_STAT, RG_DLL, RG_AID, RG_ID, RG_NONE
   } reg_e;

   function automatic logic [11:0] reg_offset(reg_e r);
      case (r)
         RG_CFG0: return OFS_CFG0;
         RG_CFG1: return OFS_CFG1;
         RG_CFG2: return OFS_CFG2;
         RG_CFG3: return OFS_CFG3;
         RG_CFG4: return OFS_CFG4;
         RG_CFG5: return OFS_CFG5;
         RG_CFG6: return OFS_CFG6;
         RG_CFG7: return OFS_CFG7;
         RG_DOUT: return OFS_DOUT;
         RG_RTN:  return OFS_RTN;
         RG_CTRL: return OFS_CTRL;
         RG_STAT: return OFS_STAT;
         RG_DLL:  return OFS_DLL;
         RG_AID:  return OFS_AID;
         RG_ID:   return OFS_ID;
         default: return 12'h000;
      endcase
   endfunction

   // registers that simply store the full bus word
   function automatic bit reg_is_plain_rw(reg_e r);
      return (r == RG_CFG0) || (r == RG_CFG1) || (r == RG_CFG2) ||
             (r == RG_CFG5) || (r == RG_CFG6) || (r == RG_CFG7) ||
             (r == RG_DOUT);
   endfunction

endpackage

// File: rtl/syscfg_addr_dec.sv
module syscfg_addr_dec
   import syscfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              bus_sel,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   output reg_e              hit_idx,
   output logic [NUM_REGS-1:0] wr_stb
);

   always_comb begin
      hit_idx = RG_NONE;
      for (int i = 0; i < int'(NUM_REGS); i++) begin
         if (bus_addr == ADDR_W'(reg_offset(reg_e'(i))))
            hit_idx = reg_e'(i);
      end
   end

   for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_stb
      assign wr_stb[g] = bus_sel && bus_write && (hit_idx == reg_e'(g));
   end

endmodule

// File: rtl/syscfg_osc_engine.sv
module syscfg_osc_engine
   import syscfg_pkg::*;
#(
   parameter int unsigned            NUM_OSC = 3,
   parameter logic [NUM_OSC*32-1:0]  OSC_RST = '0,
   localparam int unsigned           FLAT_W  = NUM_OSC * WORD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_wr,
   input  logic                 req_start,
   input  logic                 req_write,
   input  logic [CTL_FN_W-1:0]  req_fn,
   input  logic [CTL_DEV_W-1:0] req_dev,
   input  logic [WORD_W-1:0]    dout_q,
   output logic [WORD_W-1:0]    rtn_q,
   output logic [WORD_W-1:0]    stat_q,
   output logic [FLAT_W-1:0]    osc_flat
);

   logic [WORD_W-1:0] osc_q [NUM_OSC];
   logic [WORD_W-1:0] picked;
   logic              dev_ok;
   logic              req_ok;
   logic              go;

   assign dev_ok = (32'(req_dev) < NUM_OSC);
   assign req_ok = (req_fn == FN_OSC) && dev_ok;
   assign go     = ctrl_wr && req_start;

   always_comb begin
      picked = '0;
      for (int i = 0; i < int'(NUM_OSC); i++) begin
         if (32'(req_dev) == 32'(i)) picked = osc_q[i];
      end
   end

   for (genvar g = 0; g < int'(NUM_OSC); g++) begin : g_osc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            osc_q[g] <= OSC_RST[g*WORD_W +: WORD_W];
         else if (go && req_write && req_ok && (32'(req_dev) == 32'(g)))
            osc_q[g] <= dout_q;
      end
      assign osc_flat[g*WORD_W +: WORD_W] = osc_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rtn_q <= '0;
      else if (go && !req_write && req_ok)
         rtn_q <= picked;
   end

   // bit 0 done, bit 1 error; cleared by any control write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= '0;
      else if (ctrl_wr)
         stat_q <= {30'd0, req_start && !req_ok, req_start};
   end

endmodule

// File: rtl/syscfg_rdmux.sv
module syscfg_rdmux
   import syscfg_pkg::*;
(
   input  reg_e              hit_idx,
   input  logic [WORD_W-1:0] words [NUM_REGS],
   output logic [WORD_W-1:0] bus_rdata
);

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < int'(NUM_REGS); i++) begin
         if (hit_idx == reg_e'(i)) bus_rdata = words[i];
      end
   end

endmodule

// File: rtl/syscfg_ctrl.sv
module syscfg_ctrl
   import syscfg_pkg::*;
#(
   parameter int unsigned           ADDR_W   = 12,
   parameter int unsigned           NUM_OSC  = 3,
   parameter int unsigned           NUM_LEDS = 8,
   parameter int unsigned           SW_W     = 8,
   parameter logic [31:0]           CFG0_RST = 32'h0,
   parameter logic [31:0]           CFG4_VAL = 32'h0,
   parameter logic [31:0]           AID_VAL  = 32'h0,
   parameter logic [31:0]           ID_VAL   = 32'h0,
   parameter logic [NUM_OSC*32-1:0] OSC_RST  = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_write,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [SW_W-1:0]     switch_in,
   output logic                remap_o,
   output logic [NUM_LEDS-1:0] led_o
);

   localparam int unsigned FLAT_W = NUM_OSC * WORD_W;

   initial begin
      if (ADDR_W < 12 || ADDR_W > 32)
         $fatal(1, "syscfg_ctrl: ADDR_W must be 12..32");
      if (NUM_OSC < 1 || NUM_OSC > 4096)
         $fatal(1, "syscfg_ctrl: NUM_OSC must be 1..4096");
      if (NUM_LEDS < 1 || NUM_LEDS > 32)
         $fatal(1, "syscfg_ctrl: NUM_LEDS must be 1..32");
      if (SW_W < 1 || SW_W > 32)
         $fatal(1, "syscfg_ctrl: SW_W must be 1..32");
   end

   reg_e                hit_idx;
   logic [NUM_REGS-1:0] wr_stb;
   logic [WORD_W-1:0]   rd_words [NUM_REGS];
   logic [WORD_W-1:0]   ctrl_q;
   logic [WORD_W-1:0]   dll_q;
   logic [WORD_W-1:0]   rtn_q;
   logic [WORD_W-1:0]   stat_q;
   logic [FLAT_W-1:0]   osc_flat;

   syscfg_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
      .bus_sel   (bus_sel),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .hit_idx   (hit_idx),
      .wr_stb    (wr_stb)
   );

   // register storage; one variant per register kind
   for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_reg
      localparam reg_e RK = reg_e'(g);
      if (reg_is_plain_rw(RK)) begin : g_rw
         localparam logic [WORD_W-1:0] RV = (RK == RG_CFG0) ? CFG0_RST : '0;
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= RV;
            else if (wr_stb[g]) q <= bus_wdata;
         end
         assign rd_words[g] = q;
      end else if (RK == RG_CFG3) begin : g_sw
         assign rd_words[g] = WORD_W'(switch_in);
      end else if (RK == RG_CFG4) begin : g_c4
         assign rd_words[g] = CFG4_VAL;
      end else if (RK == RG_AID) begin : g_aid
         assign rd_words[g] = AID_VAL;
      end else if (RK == RG_ID) begin : g_id
         assign rd_words[g] = ID_VAL;
      end else if (RK == RG_RTN) begin : g_rtn
         assign rd_words[g] = rtn_q;
      end else if (RK == RG_STAT) begin : g_stat
         assign rd_words[g] = stat_q;
      end else if (RK == RG_CTRL) begin : g_ctrl
         assign rd_words[g] = ctrl_q;
      end else if (RK == RG_DLL) begin : g_dll
         assign rd_words[g] = dll_q;
      end else begin : g_none
         assign rd_words[g] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= CTL_RST;
      else if (wr_stb[int'(RG_CTRL)])
         ctrl_q <= bus_wdata & CTL_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dll_q <= DLL_RST;
      else if (wr_stb[int'(RG_DLL)])
         dll_q <= (bus_wdata & DLL_WRMASK) | (dll_q & ~DLL_WRMASK);
   end

   syscfg_osc_engine #(.NUM_OSC(NUM_OSC), .OSC_RST(OSC_RST)) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (wr_stb[int'(RG_CTRL)]),
      .req_start (bus_wdata[CTL_START]),
      .req_write (bus_wdata[CTL_WRITE]),
      .req_fn    (bus_wdata[CTL_FN_LSB +: CTL_FN_W]),
      .req_dev   (bus_wdata[CTL_DEV_W-1:0]),
      .dout_q    (rd_words[int'(RG_DOUT)]),
      .rtn_q     (rtn_q),
      .stat_q    (stat_q),
      .osc_flat  (osc_flat)
   );

   syscfg_rdmux rdm_i (
      .hit_idx   (hit_idx),
      .words     (rd_words),
      .bus_rdata (bus_rdata)
   );

   assign remap_o = rd_words[int'(RG_CFG0)][0];
   assign led_o   = rd_words[int'(RG_CFG1)][NUM_LEDS-1:0];

endmodule

// File: rtl/syscfg_ctrl_chk.sv
module syscfg_ctrl_chk #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned NUM_OSC = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_sel,
   input logic                  bus_write,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  wd_start,
   input logic                  wd_bit0,
   input logic [5:0]            wd_fn,
   input logic [11:0]           wd_dev,
   input logic                  remap_o,
   input logic [31:0]           ctrl_q,
   input logic [31:0]           stat_q,
   input logic [31:0]           dll_q,
   input logic [NUM_OSC*32-1:0] osc_flat
);

   logic ctrl_wr, cfg0_wr, bad_req;
   assign ctrl_wr = bus_sel && bus_write && (bus_addr == ADDR_W'(12'h0A8));
   assign cfg0_wr = bus_sel && bus_write && (bus_addr == ADDR_W'(12'h000));
   assign bad_req = (wd_fn != 6'd1) || (32'(wd_dev) >= NUM_OSC);

   AST_START_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[31]); // R6

   AST_DONE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && wd_start |=> stat_q[0]); // R7

   AST_STAT_CLEAR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && !wd_start |=> stat_q == 32'd0); // R7

   AST_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(stat_q)); // R7

   AST_BAD_REQ_KEEPS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && wd_start && bad_req |=> stat_q[1] && $stable(osc_flat)); // R10

   AST_DLL_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(dll_q[23:0])); // R11

   AST_REMAP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg0_wr |=> remap_o == $past(wd_bit0)); // R3

endmodule

bind syscfg_ctrl syscfg_ctrl_chk #(.ADDR_W(ADDR_W), .NUM_OSC(NUM_OSC)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .wd_start  (bus_wdata[31]),
   .wd_bit0   (bus_wdata[0]),
   .wd_fn     (bus_wdata[25:20]),
   .wd_dev    (bus_wdata[11:0]),
   .remap_o   (remap_o),
   .ctrl_q    (ctrl_q),
   .stat_q    (stat_q),
   .dll_q     (dll_q),
   .osc_flat  (osc_flat)
);

// File: tb/syscfg_ctrl_tb_top.sv
module syscfg_ctrl_tb_top;

   localparam logic [31:0] OSC0 = 32'd50000000;
   localparam logic [31:0] OSC1 = 32'd25000000;
   localparam logic [31:0] OSC2 = 32'd24000000;
   localparam logic [31:0] C4V  = 32'h0000_0C0F;
   localparam logic [31:0] AIDV = 32'h0200_0008;
   localparam logic [31:0] IDV  = 32'h4104_5050;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  switch_in = '0;
   logic        remap_o;
   logic [7:0]  led_o;

   always #4 clk = ~clk; // 125 MHz

   syscfg_ctrl #(
      .ADDR_W(12), .NUM_OSC(3), .NUM_LEDS(8), .SW_W(8),
      .CFG0_RST(32'h1), .CFG4_VAL(C4V), .AID_VAL(AIDV), .ID_VAL(IDV),
      .OSC_RST({OSC2, OSC1, OSC0})
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .switch_in(switch_in), .remap_o(remap_o), .led_o(led_o)
   );

   typedef struct {
      int          kind;   // 0 read data, 1 LEDs, 2 remap
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t  sb_q[$];
   event   mon_ev;
   int     n_cmp = 0;
   int     n_bad = 0;
   bit     finished = 0;

   // monitor: pops one expected item per event and compares mid-cycle
   always begin
      item_t       it;
      logic [31:0] act;
      @(mon_ev);
      #2;
      it = sb_q.pop_front();
      case (it.kind)
         1:       act = 32'(led_o);
         2:       act = 32'(remap_o);
         default: act = bus_rdata;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_write = 1'b0;
   endtask

   task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
      sb_q.push_back('{0, e, t});
      -> mon_ev;
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   task automatic exp_pin(input int k, input logic [31:0] e, input string t);
      @(negedge clk);
      sb_q.push_back('{k, e, t});
      -> mon_ev;
      @(posedge clk);
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      exp_rd(12'h000, 32'h1,         "R1 cfg0 reset");
      exp_rd(12'h0A8, 32'h0010_0000, "R1 ctrl reset");
      exp_rd(12'h100, 32'hFFFF_0001, "R1 dll reset");
      exp_rd(12'h0AC, 32'h0,         "R1 status reset");
      exp_rd(12'h0A4, 32'h0,         "R1 rtn reset");
      exp_rd(12'h0A0, 32'h0,         "R1 dout reset");
      exp_rd(12'h004, 32'h0,         "R1 cfg1 reset");
      exp_pin(2, 32'h1, "R1 R3 remap after reset");
      exp_pin(1, 32'h0, "R1 R4 leds after reset");

      // R9 reads of each oscillator's reset word
      wr(12'h0A8, 32'h8010_0000); exp_rd(12'h0A4, OSC0, "R9 R1 osc0 reset");
      exp_rd(12'h0AC, 32'h1, "R7 done after read");
      wr(12'h0A8, 32'h8010_0001); exp_rd(12'h0A4, OSC1, "R9 R1 osc1 reset");
      wr(12'h0A8, 32'h8010_0002); exp_rd(12'h0A4, OSC2, "R9 R1 osc2 reset");

      // R4 LEDs
      wr(12'h004, 32'h0000_00A5); exp_pin(1, 32'hA5, "R4 led pattern A5");
      wr(12'h004, 32'h0000_015A); exp_pin(1, 32'h5A, "R4 led bit8 ignored");
      exp_rd(12'h004, 32'h0000_015A, "R4 cfg1 readback");

      // R3 remap
      wr(12'h000, 32'hFFFF_FFFE); exp_pin(2, 32'h0, "R3 remap low");
      exp_rd(12'h000, 32'hFFFF_FFFE, "R3 cfg0 readback");
      wr(12'h000, 32'h0000_0001); exp_pin(2, 32'h1, "R3 remap high");

      // R5 read-only words and switches
      switch_in = 8'h3C;
      exp_rd(12'h00C, 32'h3C, "R5 switches");
      wr(12'h00C, 32'hFFFF_FFFF); exp_rd(12'h00C, 32'h3C, "R5 cfg3 write ignored");
      wr(12'h010, 32'h1234_5678); exp_rd(12'h010, C4V, "R5 cfg4 write ignored");
      wr(12'hFF8, 32'h0);         exp_rd(12'hFF8, AIDV, "R5 aid write ignored");
      wr(12'hFFC, 32'h0);         exp_rd(12'hFFC, IDV, "R5 id write ignored");

      // R2 map and round trips
      wr(12'h008, 32'h1111_2222); exp_rd(12'h008, 32'h1111_2222, "R2 cfg2");
      wr(12'h014, 32'h3333_4444); exp_rd(12'h014, 32'h3333_4444, "R2 cfg5");
      wr(12'h018, 32'h5555_6666); exp_rd(12'h018, 32'h5555_6666, "R2 cfg6");
      wr(12'h01C, 32'h7777_8888); exp_rd(12'h01C, 32'h7777_8888, "R2 cfg7");
      wr(12'h020, 32'hFFFF_FFFF); exp_rd(12'h020, 32'h0, "R2 unmapped 020");
      exp_rd(12'h104, 32'h0, "R2 unmapped 104");
      exp_rd(12'h002, 32'h0, "R2 unaligned 002");

      // R6 control masking; fn 0x3F invalid so R10 error
      wr(12'h0A8, 32'hFFFF_FFFF);
      exp_rd(12'h0A8, 32'h43F0_0FFF, "R6 ctrl mask");
      exp_rd(12'h0AC, 32'h3, "R10 bad function error");

      // R7 control write without start clears status
      wr(12'h0A8, 32'h0010_0002);
      exp_rd(12'h0AC, 32'h0, "R7 status cleared");

      // R8 write transaction
      wr(12'h0A0, 32'hDEAD_BEEF);
      wr(12'h0A8, 32'hC010_0002);
      exp_rd(12'h0AC, 32'h1, "R8 write done no error");
      exp_rd(12'h0A8, 32'h4010_0002, "R6 start reads zero");
      wr(12'h008, 32'h0);
      exp_rd(12'h0AC, 32'h1, "R7 done held over other write");
      wr(12'h0A8, 32'h8010_0002);
      exp_rd(12'h0A4, 32'hDEAD_BEEF, "R8 osc2 written");

      // R10 device boundary and bad function
      wr(12'h0A0, 32'h1234_5678);
      wr(12'h0A8, 32'hC010_0003);
      exp_rd(12'h0AC, 32'h3, "R10 device 3 error");
      exp_rd(12'h0A4, 32'hDEAD_BEEF, "R10 rtn unchanged");
      wr(12'h0A8, 32'hC020_0000);
      exp_rd(12'h0AC, 32'h3, "R10 function 2 error");
      wr(12'h0A8, 32'h8010_0FFF);
      exp_rd(12'h0AC, 32'h3, "R10 read device FFF error");
      exp_rd(12'h0A4, 32'hDEAD_BEEF, "R10 rtn unchanged on bad read");
      wr(12'h0A8, 32'h8010_0000);
      exp_rd(12'h0A4, OSC0, "R10 osc0 untouched");
      wr(12'h0A8, 32'h8010_0001);
      exp_rd(12'h0A4, OSC1, "R10 osc1 untouched");

      // R11 DLL top byte
      wr(12'h100, 32'h1234_5678);
      exp_rd(12'h100, 32'h12FF_0001, "R11 dll top byte");

      // R12 rtn and status read-only
      wr(12'h0A4, 32'hAAAA_AAAA);
      exp_rd(12'h0A4, OSC1, "R12 rtn write ignored");
      wr(12'h0AC, 32'h0);
      exp_rd(12'h0AC, 32'h1, "R12 status write ignored");

      @(negedge clk);
      #3;
      finished = 1;
      summary();
   end

endmodule